// File: doc/BRIEF.md
# Sensor Register Initialization Sequencer

After reset, this block walks a constant table of image-sensor register settings. For each setting it asks a separate I2C write master for exactly one register write. Each table word packs an 8-bit register address above a 16-bit register value. The sequencer keeps an index into the table and shows the selected word to the master. It then pulses a start request and waits for the master's completion report.

The index moves forward only when the master reports that every acknowledge in the transfer was good. A transfer that reports an acknowledge error is sent again from the same entry after a programmable idle gap, so a sensor that is slow to wake up still ends up fully configured. Once the last entry has been written, the block raises a done flag and holds it. It then issues no further requests until a synchronous reset starts the walk again from entry zero.

The table contents are a parameter. A different sensor setup only needs a new parameter value; the control logic does not change.

Top module: `sensor_init_seq`

## Requirements
- R1: While `rst_n` is low and on the first edge after it, `cfg_index` is 0, `config_done` is 0 and `mst_go` is 0. The first request pulse appears at the first rising edge where `rst_n` is high and `mst_busy` is low.
- R2: Entry k of `CFG_TABLE` sits at bits [24k+23:24k]. Its top 8 bits drive `mst_reg` and its low 16 bits drive `mst_val` whenever `cfg_index` equals k.
- R3: `mst_go` is high for exactly one clock cycle per request.
- R4: `mst_go` is raised only at an edge where `mst_busy` was sampled low. While the master stays busy, no request is issued.
- R5: `cfg_index` increases by exactly one, and only at an edge where `mst_done` is high with `mst_ack_err` low during an outstanding request.
- R6: A completion with `mst_ack_err` high leaves `cfg_index` unchanged. The same entry is requested again, with the new `mst_go` at the edge RETRY_GAP+2 cycles after the failing completion was sampled.
- R7: After a good completion that is not the last, the next request is issued at the first edge after the completion edge where `mst_busy` is low.
- R8: `config_done` rises at the edge that samples the good completion of the last entry. `cfg_index` then equals TABLE_DEPTH. `config_done` stays high and `mst_go` stays low until reset.
- R9: A synchronous reset in the middle of the table abandons the walk and restarts it from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_busy | input | 1 | Write master is occupied with a transfer |
| mst_done | input | 1 | One-cycle completion report from the write master |
| mst_ack_err | input | 1 | Qualifies `mst_done`: some acknowledge was missing |
| mst_go | output | 1 | One-cycle request for a register write |
| mst_reg | output | 8 | Register address of the current entry |
| mst_val | output | 16 | Register value of the current entry |
| cfg_index | output | IDX_W | Index of the entry being written, TABLE_DEPTH when finished |
| config_done | output | 1 | All entries written successfully |

## Verification
A behavioural master answers each request and is swept over these dimensions:
- response latency;
- extra busy time after completion;
- busy held at reset release;
- per-entry counts of acknowledge failures from zero to two.

Failure counts separate a correct retry, which repeats the same word with an exact gap, from premature advancing or from early or late re-requests. Extra busy time and busy at start separate a request that is correctly withheld from one sent to an occupied master. One run is cut by reset part way through the table, to tell a true restart from a resumed walk. A quiet window after completion shows whether the done flag holds and whether stray requests appear.

// File: rtl/sis_pkg.sv
// Package: shared types for the sensor initialization sequencer.
// Assumes a table word of one 8-bit register address over a 16-bit value.
package sis_pkg;

    localparam int unsigned REG_W  = 8;
    localparam int unsigned VAL_W  = 16;
    localparam int unsigned WORD_W = REG_W + VAL_W;

    typedef struct packed {
        logic [REG_W-1:0] reg_addr;
        logic [VAL_W-1:0] value;
    } cfg_word_t;

    typedef enum logic [1:0] {
        ST_ISSUE = 2'd0,
        ST_WAIT  = 2'd1,
        ST_GAP   = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/sis_table.sv
// Module: constant configuration table.
// Unpacks the flat parameter into words and selects the word at idx.
// Assumes entry k lives at bits [24k+23:24k]; an index outside the table yields zero.
module sis_table
    import sis_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned IDX_W = 3,
    parameter logic [DEPTH*WORD_W-1:0] TABLE = '0
) (
    input  logic [IDX_W-1:0] idx,
    output cfg_word_t        word
);

    cfg_word_t rom [DEPTH];

    // Split the flat table into per-entry words.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign rom[g] = cfg_word_t'(TABLE[g*WORD_W +: WORD_W]);
    end

    // Select the entry that matches the current index.
    always_comb begin
        word = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (idx == IDX_W'(i)) begin
                word = rom[i];
            end
        end
    end

endmodule

// File: rtl/sis_gap_timer.sv
// Module: retry idle-gap timer.
// Loads GAP on load and counts down to zero; expired is high at zero.
// Assumes GAP >= 1 so a load is never expired on the following cycle.
module sis_gap_timer #(
    parameter int unsigned GAP = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int unsigned CNT_W = (GAP < 2) ? 1 : $clog2(GAP + 1);

    logic [CNT_W-1:0] cnt;

    // Reload on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(GAP);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // A fresh load must hold off the retry for at least one cycle (R6).
    p_gap_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);

endmodule

// File: rtl/sis_ctrl.sv
// Module: sequencing state machine and table index.
// Issues one request per entry while the master is idle, advances on a good
// completion, schedules a gapped retry on an acknowledge error, and flags done.
// Assumes the master reports exactly one mst_done per accepted mst_go.
module sis_ctrl
    import sis_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mst_busy,
    input  logic             mst_done,
    input  logic             mst_ack_err,
    input  logic             gap_expired,
    output logic             gap_load,
    output logic             mst_go,
    output logic [IDX_W-1:0] idx,
    output logic             cfg_done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    seq_state_t state;
    logic       ok_done;
    logic       bad_done;

    // Classify the master's completion report while a request is outstanding.
    always_comb begin
        ok_done  = (state == ST_WAIT) && mst_done && !mst_ack_err;
        bad_done = (state == ST_WAIT) && mst_done &&  mst_ack_err;
    end

    assign gap_load = bad_done;

    // Main sequencing: request, wait, retry gap, finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_ISSUE;
            idx      <= '0;
            mst_go   <= 1'b0;
            cfg_done <= 1'b0;
        end else begin
            mst_go <= 1'b0;
            case (state)
                ST_ISSUE: begin
                    if (!mst_busy) begin
                        mst_go <= 1'b1;
                        state  <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (ok_done) begin
                        idx <= idx + 1'b1;
                        if (idx == LAST_IDX) begin
                            state    <= ST_DONE;
                            cfg_done <= 1'b1;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end else if (bad_done) begin
                        state <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_expired) begin
                        state <= ST_ISSUE;
                    end
                end
                default: begin
                    state <= ST_DONE;
                end
            endcase
        end
    end

    // Request strobe is a single cycle (R3).
    p_go_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mst_go |=> !mst_go);

    // A request only follows an edge that saw the master idle (R4).
    p_go_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mst_go |-> $past(!mst_busy));

    // Index moves by one and only after a clean completion (R5).
    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (idx != $past(idx))) |->
            ((idx == IDX_W'($past(idx) + 1'b1)) && $past(mst_done && !mst_ack_err)));

    // Done is sticky until reset (R8).
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);

    // No further request once the table is finished (R8).
    p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> !mst_go);

endmodule

// File: rtl/sensor_init_seq.sv
// Module: top of the sensor register initialization sequencer.
// Connects the constant table, the sequencing FSM and the retry gap timer.
// Assumes TABLE_DEPTH >= 1 and RETRY_GAP >= 1 (RETRY_GAP in clock cycles,
// chosen to cover at least one SCL period of the write master).
module sensor_init_seq
    import sis_pkg::*;
#(
    parameter int unsigned TABLE_DEPTH = 4,
    parameter int unsigned RETRY_GAP   = 500,
    parameter int unsigned IDX_W       = $clog2(TABLE_DEPTH + 1),
    parameter logic [TABLE_DEPTH*WORD_W-1:0] CFG_TABLE = {
        24'h35_0008, 24'h20_0040, 24'h01_01EA, 24'h09_0300
    }
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mst_busy,
    input  logic             mst_done,
    input  logic             mst_ack_err,
    output logic             mst_go,
    output logic [REG_W-1:0] mst_reg,
    output logic [VAL_W-1:0] mst_val,
    output logic [IDX_W-1:0] cfg_index,
    output logic             config_done
);

    cfg_word_t cur_word;
    logic      gap_load;
    logic      gap_expired;

    sis_table #(
        .DEPTH (TABLE_DEPTH),
        .IDX_W (IDX_W),
        .TABLE (CFG_TABLE)
    ) u_table (
        .idx  (cfg_index),
        .word (cur_word)
    );

    sis_ctrl #(
        .DEPTH (TABLE_DEPTH),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mst_busy    (mst_busy),
        .mst_done    (mst_done),
        .mst_ack_err (mst_ack_err),
        .gap_expired (gap_expired),
        .gap_load    (gap_load),
        .mst_go      (mst_go),
        .idx         (cfg_index),
        .cfg_done    (config_done)
    );

    sis_gap_timer #(
        .GAP (RETRY_GAP)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_expired)
    );

    // Presented word follows the table entry at the index (R2).
    assign mst_reg = cur_word.reg_addr;
    assign mst_val = cur_word.value;

    // Finished means the index has run off the end of the table (R8).
    p_done_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        config_done |-> (cfg_index == IDX_W'(TABLE_DEPTH)));

endmodule

// File: tb/sim_sensor_init_seq.sv
// Bench: behavioural write master swept over latency, busy patterns and
// acknowledge failure counts; timing expectations computed from the requirements.
module sim_sensor_init_seq;

    localparam int unsigned DEPTH = 4;
    localparam int unsigned GAP   = 5;
    localparam int unsigned IW    = 3;
    localparam logic [DEPTH*24-1:0] TBL = {
        24'hA7_5A3C, 24'h3E_0001, 24'h01_01EA, 24'h09_FF00
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mst_busy = 1'b0;
    logic          mst_done = 1'b0;
    logic          mst_ack_err = 1'b0;
    logic          mst_go;
    logic [7:0]    mst_reg;
    logic [15:0]   mst_val;
    logic [IW-1:0] cfg_index;
    logic          config_done;

    int vectors = 0;
    int fails   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sensor_init_seq #(
        .TABLE_DEPTH (DEPTH),
        .RETRY_GAP   (GAP),
        .IDX_W       (IW),
        .CFG_TABLE   (TBL)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .mst_busy    (mst_busy),
        .mst_done    (mst_done),
        .mst_ack_err (mst_ack_err),
        .mst_go      (mst_go),
        .mst_reg     (mst_reg),
        .mst_val     (mst_val),
        .cfg_index   (cfg_index),
        .config_done (config_done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Count negedges until mst_go is seen; 0 on timeout.
    task automatic wait_go(output int n);
        n = 0;
        for (int k = 1; k <= 400; k++) begin
            @(negedge clk);
            if (mst_go) begin
                n = k;
                break;
            end
        end
    endtask

    initial begin
        for (int s = 0; s < 14; s++) begin
            int lat, extra, sbusy, abort_at, n;
            int nfail [DEPTH];
            lat      = 1 + (s % 3) * 2;
            extra    = ((s / 3) % 2) * 3;
            sbusy    = s % 4;
            abort_at = (s == 7 || s == 11) ? 2 : -1;
            for (int i = 0; i < DEPTH; i++) nfail[i] = (s + i) % 3;
            if (s == 0) for (int i = 0; i < DEPTH; i++) nfail[i] = 0;

            // Reset, with busy optionally held across release.
            @(negedge clk);
            rst_n = 1'b0; mst_done = 1'b0; mst_ack_err = 1'b0;
            mst_busy = (sbusy != 0);
            repeat (3) @(negedge clk);
            chk("R1", "reset go", 32'(mst_go), 0);
            chk("R1", "reset done", 32'(config_done), 0);
            chk("R1", "reset index", 32'(cfg_index), 0);
            rst_n = 1'b1;
            // First request: one edge after release, or once busy falls (R1, R4).
            n = 0;
            for (int k = 1; k <= 400; k++) begin
                @(negedge clk);
                if (mst_go) begin n = k; break; end
                if (k == sbusy) mst_busy = 1'b0;
            end
            chk(sbusy != 0 ? "R4" : "R1", "first go delay", 32'(n), 32'(sbusy + 1));

            for (int i = 0; i < DEPTH; i++) begin
                if (i == abort_at) break;
                for (int a = 0; a <= nfail[i]; a++) begin
                    bit bad;
                    int exp_n;
                    bad = (a < nfail[i]);
                    // At the negedge where go is visible.
                    chk("R2", "reg addr", 32'(mst_reg), 32'(TBL[i*24+16 +: 8]));
                    chk("R2", "reg value", 32'(mst_val), 32'(TBL[i*24 +: 16]));
                    chk("R5", "index at request", 32'(cfg_index), 32'(i));
                    @(negedge clk);
                    chk("R3", "go single cycle", 32'(mst_go), 0);
                    mst_busy = 1'b1;
                    repeat (lat) @(negedge clk);
                    mst_done = 1'b1; mst_ack_err = bad;
                    @(negedge clk);
                    mst_done = 1'b0; mst_ack_err = 1'b0;
                    if (extra == 0 || bad) mst_busy = 1'b0;
                    if (bad) begin
                        chk("R6", "index held on ack error", 32'(cfg_index), 32'(i));
                    end else begin
                        chk("R5", "index advanced", 32'(cfg_index), 32'(i + 1));
                        chk("R8", "done flag", 32'(config_done), 32'(i == DEPTH - 1));
                    end
                    if (!bad && i == DEPTH - 1) break;
                    if (!bad && i + 1 == abort_at) break;
                    // Time from the completion negedge to the next request.
                    n = 1;
                    for (int k = 2; k <= 400; k++) begin
                        @(negedge clk);
                        if (mst_go) begin n = k; break; end
                        if (k == 1 + extra) mst_busy = 1'b0;
                        if (k == 400) n = 0;
                    end
                    exp_n = bad ? GAP + 3 : extra + 2;
                    chk(bad ? "R6" : "R7", "request spacing", 32'(n), 32'(exp_n));
                end
            end

            if (abort_at >= 0) begin
                // Mid-sequence reset must restart from entry 0 (R9).
                rst_n = 1'b0; mst_busy = 1'b0;
                @(negedge clk);
                chk("R9", "index after abort reset", 32'(cfg_index), 0);
                rst_n = 1'b1;
                wait_go(n);
                chk("R9", "restart go delay", 32'(n), 1);
                chk("R9", "restart reg addr", 32'(mst_reg), 32'(TBL[16 +: 8]));
                chk("R9", "restart reg value", 32'(mst_val), 32'(TBL[0 +: 16]));
            end else begin
                // Quiet window: done holds, no requests, index at depth (R8).
                for (int k = 0; k < 12; k++) begin
                    @(negedge clk);
                    chk("R8", "no go after done", 32'(mst_go), 0);
                    chk("R8", "done held", 32'(config_done), 1);
                end
                chk("R8", "final index", 32'(cfg_index), 32'(DEPTH));
            end
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule